// File: doc/BRIEF.md
# Endpoint-0 Descriptor Reply Engine

This block serves descriptor data to the host on control endpoint 0 with no processor work per packet. Software programs a 16-bit start address and a 16-bit byte count, one byte at a time, and then writes a start command. From then on the engine answers each IN token. For each one it streams the next chunk of bytes from a local descriptor memory into the endpoint-0 transmit path. A chunk is never longer than the endpoint's maximum packet size. The engine waits for the host's acknowledgement before it moves on.

The address and count registers are the engine's working state. Each acknowledged packet moves the address forward by the bytes sent and lowers the count by the same amount. Software must therefore rewrite both before each new start. A packet that fails is sent again unchanged. A transfer whose length is an exact multiple of the packet size can be closed with an empty packet when the short-packet enable is set.

The controller has four states:
- `ST_IDLE` goes to `ST_WAIT_IN` on a start command.
- `ST_WAIT_IN` goes to `ST_SEND` on an IN token.
- `ST_SEND` goes to `ST_WAIT_ACK` after the last byte of the chunk, or after a single cycle for an empty packet.
- `ST_WAIT_ACK` leaves in one of two ways:
  - On an acknowledgement it goes to `ST_IDLE` if the packet was the final one, and to `ST_WAIT_IN` otherwise.
  - On a failure report it goes to `ST_WAIT_IN`.

Top module: `desc_reply_engine`

## Requirements
- R1: After reset the following hold:
  - `busy` is 0.
  - `tx_valid`, `tx_last` and `tx_empty` are 0.
  - `mem_addr` is 0.
- R2: While idle, a write with `cfg_sel` = 0, 1, 2 or 3 loads, in that order: the low address byte, the high address byte, the low size byte and the high size byte. Outside `ST_SEND`, `mem_addr` shows the address register.
- R3: A write with `cfg_sel` = 4 and `cfg_wdata[0]` = 1 sets `busy` from the next clock edge. A write with `cfg_sel` = 4 and bit 0 = 0 has no effect and leaves nothing stored.
- R4: Each IN token is answered, from the following cycle, by a packet of length min(`max_pkt`, remaining size). Its bytes come one per cycle from consecutive addresses starting at the address register. `tx_last` is set on the final byte only.
- R5: The address register and the size register change only on an acknowledgement (`pkt_ack` in `ST_WAIT_ACK`). The address then rises by the packet length, wrapping at 16 bits, and the size falls by the same amount.
- R6: A `pkt_fail` in `ST_WAIT_ACK` leaves the address and size unchanged. The next IN token then resends the identical chunk.
- R7: A transfer's final packet is an empty packet in one case only: the size reaches 0 on a full-length packet while `short_pkt_en` = 1. An empty packet is a single-cycle `tx_empty` pulse with `tx_valid` = 0. With `short_pkt_en` = 0 the transfer ends after that full-length packet.
- R8: `busy` falls in the cycle after the acknowledgement of the final packet. The final packet is either one shorter than `max_pkt`, or a full one that brings the size to 0 while `short_pkt_en` = 0.
- R9: While `busy` is 1, writes to the address, size and start controls are ignored.
- R10: If the size is 0 at start, the first IN token is answered with an empty packet and the transfer then ends.
- R11: No packet carries more than `max_pkt` bytes. `tx_valid` and `tx_empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0/1 address low/high, 2/3 size low/high, 4 control |
| cfg_wdata | input | 8 | Configuration write data; bit 0 of a control write starts the engine |
| max_pkt | input | MPS_W | Endpoint-0 maximum packet size, nonzero |
| short_pkt_en | input | 1 | Enables the closing empty packet after an exact multiple |
| in_token | input | 1 | IN token received for endpoint 0 |
| pkt_ack | input | 1 | Host acknowledged the last packet |
| pkt_fail | input | 1 | Last packet was not acknowledged |
| mem_addr | output | 16 | Descriptor memory read address |
| mem_rdata | input | 8 | Descriptor memory data for `mem_addr`, same cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_empty | output | 1 | Zero-length packet pulse |
| busy | output | 1 | Engine is running a transfer |

## Verification
The assertions take the following for granted:
- `max_pkt` is nonzero and does not change while `busy` is high.
- `short_pkt_en` does not change while `busy` is high.
- `in_token` arrives only in `ST_WAIT_IN`.
- `pkt_ack` and `pkt_fail` arrive only in `ST_WAIT_ACK`, and never together.

The bench meets these conditions as follows:
- It sets the packet size and the short-packet enable before each start, and changes them only after `busy` has fallen.
- It raises a token only once the previous packet has been fully received.
- It reports the outcome with one pulse of either `pkt_ack` or `pkt_fail`, never both.

Descriptor memory is modelled as a combinational function of `mem_addr`, which satisfies the same-cycle read rule.

// File: rtl/desc_reply_pkg.sv
package desc_reply_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SIZE_LO = 3'd2;
    localparam logic [SEL_W-1:0] SEL_SIZE_HI = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_IN  = 2'd1,
        ST_SEND     = 2'd2,
        ST_WAIT_ACK = 2'd3
    } dr_state_e;
endpackage

// File: rtl/dr_regfile.sv
module dr_regfile
    import desc_reply_pkg::*;
#(
    parameter int MPS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              lock,
    input  logic              adv,
    input  logic [MPS_W-1:0]  adv_len,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] size_q,
    output logic              start_req
);
    localparam int HI_LSB = WORD_W - BYTE_W;

    logic wr_ok;
    logic [WORD_W-1:0] step;

    assign wr_ok     = cfg_wr && !lock;
    assign step      = WORD_W'(adv_len);
    assign start_req = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
        end else if (adv) begin
            addr_q <= addr_q + step;
            size_q <= size_q - step;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_ADDR_LO: addr_q[BYTE_W-1:0]      <= cfg_wdata;
                SEL_ADDR_HI: addr_q[WORD_W-1:HI_LSB] <= cfg_wdata;
                SEL_SIZE_LO: size_q[BYTE_W-1:0]      <= cfg_wdata;
                SEL_SIZE_HI: size_q[WORD_W-1:HI_LSB] <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // R9
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !adv) |=> ($stable(addr_q) && $stable(size_q)));

    // R5
    size_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (size_q >= step));
endmodule

// File: rtl/dr_chunk.sv
module dr_chunk
    import desc_reply_pkg::*;
#(
    parameter int MPS_W = 7
) (
    input  logic [WORD_W-1:0] size_q,
    input  logic [MPS_W-1:0]  max_pkt,
    input  logic              short_pkt_en,
    output logic [MPS_W-1:0]  pkt_len,
    output logic              final_pkt
);
    logic [WORD_W-1:0] mps_w;
    logic              short_chunk;

    always_comb begin
        mps_w       = WORD_W'(max_pkt);
        short_chunk = size_q < mps_w;
        pkt_len     = short_chunk ? size_q[MPS_W-1:0] : max_pkt;
        final_pkt   = short_chunk || (!short_pkt_en && (size_q == mps_w));
    end
endmodule

// File: rtl/dr_fsm.sv
module dr_fsm
    import desc_reply_pkg::*;
#(
    parameter int MPS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              in_token,
    input  logic              pkt_ack,
    input  logic              pkt_fail,
    input  logic [MPS_W-1:0]  pkt_len,
    input  logic              final_pkt,
    input  logic [MPS_W-1:0]  max_pkt,
    input  logic [WORD_W-1:0] addr_q,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_addr,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    output logic              tx_empty,
    output logic              busy,
    output logic              adv
);
    dr_state_e        state, state_nx;
    logic [MPS_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == MPS_W'(pkt_len - 1'b1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT_IN)
                cnt <= '0;
            else if (tx_valid)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_req) state_nx = ST_WAIT_IN;
            ST_WAIT_IN:  if (in_token) state_nx = ST_SEND;
            ST_SEND:     if (pkt_len == '0 || at_end) state_nx = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (pkt_ack)
                    state_nx = final_pkt ? ST_IDLE : ST_WAIT_IN;
                else if (pkt_fail)
                    state_nx = ST_WAIT_IN;
            end
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_empty = 1'b0;
        adv      = 1'b0;
        mem_addr = addr_q;
        busy     = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:     ;
            ST_WAIT_IN:  ;
            ST_SEND: begin
                mem_addr = addr_q + WORD_W'(cnt);
                tx_empty = (pkt_len == '0);
                tx_valid = (pkt_len != '0);
                tx_last  = (pkt_len != '0) && at_end;
            end
            ST_WAIT_ACK: adv = pkt_ack;
            default:     ;
        endcase
        tx_data = tx_valid ? mem_rdata : '0;
    end

    // R11
    pkt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (cnt < max_pkt));

    // R11
    mps_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (max_pkt != '0));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> (tx_valid && (mem_addr == WORD_W'($past(mem_addr) + 1'b1))));

    // R8
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && final_pkt) |=> !busy);

    // R6
    retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_ACK && pkt_fail && !pkt_ack) |=> (state == ST_WAIT_IN && $stable(addr_q)));
endmodule

// File: rtl/desc_reply_engine.sv
module desc_reply_engine
    import desc_reply_pkg::*;
#(
    parameter int MPS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [MPS_W-1:0]  max_pkt,
    input  logic              short_pkt_en,
    input  logic              in_token,
    input  logic              pkt_ack,
    input  logic              pkt_fail,
    output logic [15:0]       mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_empty,
    output logic              busy
);
    logic [WORD_W-1:0] addr_q, size_q;
    logic              start_req, adv, final_pkt;
    logic [MPS_W-1:0]  pkt_len;

    dr_regfile #(.MPS_W(MPS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lock(busy), .adv(adv), .adv_len(pkt_len),
        .addr_q(addr_q), .size_q(size_q), .start_req(start_req)
    );

    dr_chunk #(.MPS_W(MPS_W)) u_chunk (
        .size_q(size_q), .max_pkt(max_pkt), .short_pkt_en(short_pkt_en),
        .pkt_len(pkt_len), .final_pkt(final_pkt)
    );

    dr_fsm #(.MPS_W(MPS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .in_token(in_token),
        .pkt_ack(pkt_ack), .pkt_fail(pkt_fail), .pkt_len(pkt_len),
        .final_pkt(final_pkt), .max_pkt(max_pkt), .addr_q(addr_q),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_empty(tx_empty),
        .busy(busy), .adv(adv)
    );

    // R11
    tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, tx_empty}));
endmodule

// File: tb/desc_reply_engine_test.sv
module desc_reply_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int MPS_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [MPS_W-1:0] max_pkt = 7'd4;
    logic short_pkt_en = 1'b0;
    logic in_token = 1'b0, pkt_ack = 1'b0, pkt_fail = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0] mem_rdata, tx_data;
    logic tx_valid, tx_last, tx_empty, busy;

    int checks = 0;
    int failures = 0;

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return {a[6:0], a[7]} ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = pattern(mem_addr);

    desc_reply_engine #(.MPS_W(MPS_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .max_pkt(max_pkt), .short_pkt_en(short_pkt_en),
        .in_token(in_token), .pkt_ack(pkt_ack), .pkt_fail(pkt_fail),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_empty(tx_empty), .busy(busy)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] s);
        wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
        wr(3'd2, s[7:0]); wr(3'd3, s[15:8]);
    endtask

    task automatic pulse_ack();
        pkt_ack = 1'b1; @(negedge clk); pkt_ack = 1'b0;
    endtask

    task automatic pulse_fail();
        pkt_fail = 1'b1; @(negedge clk); pkt_fail = 1'b0;
    endtask

    task automatic get_packet(input logic [15:0] a, input int len, input string req);
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
        if (len == 0) begin
            chk({req, " empty pulse"}, tx_empty, 1);
            chk({req, " no valid on empty"}, tx_valid, 0);
            @(negedge clk);
        end else begin
            for (int i = 0; i < len; i++) begin
                logic [15:0] ai;
                ai = a + 16'(i);
                chk({req, " valid"}, tx_valid, 1);
                chk({req, " data"}, tx_data, pattern(ai));
                chk({req, " last"}, tx_last, (i == len - 1));
                @(negedge clk);
            end
        end
        chk("R11 packet ends at length", {tx_valid, tx_empty}, 0);
    endtask

    task automatic run(input logic [15:0] addr, input int size, input int mps,
                       input logic sen, input logic retry);
        int rem;
        int plen;
        logic [15:0] a;
        logic first;
        max_pkt = MPS_W'(mps);
        short_pkt_en = sen;
        load(addr, 16'(size));
        wr(3'd4, 8'h01);
        chk("R3 busy after start", busy, 1);
        a = addr; rem = size; first = 1'b1;
        while (1) begin
            plen = (rem < mps) ? rem : mps;
            get_packet(a, plen, (plen == 0) ? ((size == 0) ? "R10" : "R7") : "R4");
            if (retry && first) begin
                pulse_fail();
                chk("R6 address held after fail", mem_addr, a);
                get_packet(a, plen, "R6 resend");
            end
            first = 1'b0;
            pulse_ack();
            rem = rem - plen;
            a = a + 16'(plen);
            chk("R5 address advanced", mem_addr, a);
            if (plen < mps || (!sen && rem == 0)) begin
                chk("R8 busy cleared", busy, 0);
                break;
            end
            chk("R8 busy held", busy, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", busy, 0);
        chk("R1 tx", {tx_valid, tx_last, tx_empty}, 0);
        chk("R1 mem_addr", mem_addr, 0);

        // R2
        load(16'h1234, 16'd5);
        chk("R2 address visible", mem_addr, 16'h1234);

        // R3: control write with bit0 clear does nothing
        wr(3'd4, 8'h00);
        chk("R3 no start on bit0=0", busy, 0);
        wr(3'd4, 8'hFE);
        chk("R3 no start on bit0=0 others set", busy, 0);

        // R9: writes ignored while running
        max_pkt = 7'd4; short_pkt_en = 1'b0;
        load(16'h0100, 16'd6);
        wr(3'd4, 8'h01);
        wr(3'd0, 8'hAA); wr(3'd1, 8'h55); wr(3'd2, 8'h01); wr(3'd3, 8'h00);
        wr(3'd4, 8'h01);
        chk("R9 address untouched", mem_addr, 16'h0100);
        get_packet(16'h0100, 4, "R9");
        pulse_ack();
        chk("R9 address after ack", mem_addr, 16'h0104);
        get_packet(16'h0104, 2, "R9 size untouched");
        pulse_ack();
        chk("R9 done", busy, 0);

        // Sweep: packet sizes, transfer lengths, short-packet enable (R4 R5 R6 R7 R8 R10)
        for (int m = 1; m <= 6; m++) begin
            for (int s = 0; s <= 10; s++) begin
                for (int e = 0; e < 2; e++) begin
                    int mps;
                    mps = (m == 6) ? 8 : m;
                    run(16'hFFF0 + 16'(s * 7 + mps), s, mps, e[0], ((s + mps) % 3) == 0);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule